// File: doc/BRIEF.md
# T1 Data-Link Bit-Oriented Message Controller

This block carries synchronization status messages over the facility data link of a T1 line that uses extended superframe (ESF) framing. A 6-bit message code is placed in a 16-bit bit-oriented pattern that the framer sends on the link. The generator sends that pattern over and over while its send control is set. When the send control is clear, the link carries idle flag octets. The detector searches the received data-link bits for the same pattern. It accepts a code only after the code has repeated unchanged for a set number of back-to-back patterns. It then reports the code and raises a sticky change-of-state event. The event drives an interrupt through a mask.

The surrounding framer extracts and inserts the data-link bits. It gives a single strobe on each data-link bit slot, which falls once every other ESF frame. One bit is consumed and one bit is produced per strobe. The function operates only in T1 mode. When the mode input is low, the generator is frozen and the detector is held clear.

Top module: `boc_link_ctrl`

## Requirements
- R1: With the send control low, the transmit bit stream is the idle flag octet 0x7E repeated. The bit on `tx_dl_bit` before the first strobe after reset is 0.
- R2: With the send control high, each 16-bit transmit pattern is eight 1s, then a 0, then the six code bits least-significant bit first, then a 0. The pattern repeats back to back while the send control stays high.
- R3: The send control and the code are sampled only when a 16-bit pattern completes. Raising or clearing the send control part-way through a pattern lets that pattern finish unchanged, and the next pattern follows the new setting.
- R4: A received code becomes valid when it has been seen in ACCEPT_CNT (default 3) identical, back-to-back received patterns (patterns exactly 16 strobes apart). `rx_valid` then goes high and `rx_code` holds the code.
- R5: A pattern that is not exactly 16 strobes after the previous detected pattern, or that holds a different code, restarts the repetition count at one.
- R6: While a code is valid, a different code that meets R4 replaces it in `rx_code`. `rx_valid` stays high.
- R7: When LOSS_PATS×16 strobes (default 64) pass without a pattern that carries the valid code, `rx_valid` goes low.
- R8: `event_flag` is set in the cycle in which `rx_valid` or `rx_code` changes because of R4, R6 or R7. It stays set until `event_clr` is pulsed, and a new change wins over a clear in the same cycle. `irq` equals `event_flag` when `irq_en` is high and is 0 otherwise.
- R9: Clock cycles without a strobe change neither the transmit bit nor the detector state, and they do not count towards R7.
- R10: With `t1_mode` low, strobes are ignored and the transmit bit holds. `rx_valid` is low from the next cycle on, with no event raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_mode | input | 1 | Enables the function (T1 operation) |
| dl_strobe | input | 1 | One-cycle strobe per data-link bit slot |
| send_en | input | 1 | Send control for the transmit code |
| tx_code | input | 6 | Code to transmit |
| tx_dl_bit | output | 1 | Current transmit data-link bit |
| rx_dl_bit | input | 1 | Received data-link bit, taken on the strobe |
| rx_code | output | 6 | Last validated received code |
| rx_valid | output | 1 | A validated code is present |
| event_clr | input | 1 | Clears the change-of-state event |
| irq_en | input | 1 | Interrupt enable (mask) |
| event_flag | output | 1 | Sticky change-of-state event |
| irq | output | 1 | Masked interrupt |

## Verification
The bench raises and clears the send control in the middle of a pattern. A generator that reacts at once would produce a cut or mixed pattern on the link. It repeats a code only twice, and it breaks a repetition with an idle gap. A detector that counts patterns that are not back to back, or that forgets to restart the count, would accept the code too early. It checks the loss boundary exactly: the code is still valid after 48 silent strobes and lost at the 64th. An off-by-one timeout would fail one of those two checks. It also holds the strobe low for a long stretch and turns the T1 mode off, which catches a detector that times out on clock cycles instead of strobes, or that raises an event when it is cleared.

// File: rtl/boc_pkg.sv
package boc_pkg;
    localparam int CODE_W  = 6;
    localparam int LEAD_W  = 8;
    localparam int PAT_LEN = LEAD_W + CODE_W + 2;
    localparam int PCNT_W  = $clog2(PAT_LEN);

    localparam logic [PAT_LEN-1:0] IDLE_WORD = {(PAT_LEN/8){8'h7E}};

    // Pattern word, bit 0 goes out first.
    function automatic logic [PAT_LEN-1:0] boc_frame(input logic [CODE_W-1:0] c);
        return {1'b0, c, 1'b0, {LEAD_W{1'b1}}};
    endfunction

    function automatic logic boc_is_frame(input logic [PAT_LEN-1:0] w);
        return (w[LEAD_W-1:0] == {LEAD_W{1'b1}}) && !w[LEAD_W] && !w[PAT_LEN-1];
    endfunction

    function automatic logic [CODE_W-1:0] boc_field(input logic [PAT_LEN-1:0] w);
        return w[PAT_LEN-2 -: CODE_W];
    endfunction
endpackage

// File: rtl/boc_tx_gen.sv
module boc_tx_gen
    import boc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              send_en,
    input  logic [CODE_W-1:0] code,
    output logic              bit_out
);
    typedef struct packed {
        logic [PAT_LEN-1:0] sh;
        logic [PCNT_W-1:0]  cnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.cnt == PCNT_W'(PAT_LEN - 1)) begin
                st_d.cnt = '0;
                st_d.sh  = send_en ? boc_frame(code) : IDLE_WORD;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.sh  = st_q.sh >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= IDLE_WORD;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.sh[0];
endmodule

// File: rtl/boc_rx_detect.sv
module boc_rx_detect
    import boc_pkg::*;
#(
    parameter int ACCEPT_CNT = 3,
    parameter int LOSS_PATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              adv,
    input  logic              bit_in,
    output logic [CODE_W-1:0] code,
    output logic              valid,
    output logic              change
);
    localparam int LOSS_LIM = LOSS_PATS * PAT_LEN;
    localparam int LOSS_W   = $clog2(LOSS_LIM + 1);
    localparam int REP_W    = $clog2(ACCEPT_CNT + 1);
    localparam int GAP_W    = $clog2(PAT_LEN + 1);

    typedef struct packed {
        logic [PAT_LEN-1:0] win;
        logic [GAP_W-1:0]   gap;
        logic [CODE_W-1:0]  cand;
        logic               cand_vld;
        logic [REP_W-1:0]   rep;
        logic [LOSS_W-1:0]  loss;
        logic               valid;
        logic [CODE_W-1:0]  code;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   chg_d;

    logic [PAT_LEN-1:0] w;
    logic               hit, consec, accept, keep;
    logic [CODE_W-1:0]  hc;

    always_comb begin
        st_d   = st_q;
        chg_d  = 1'b0;
        w      = {bit_in, st_q.win[PAT_LEN-1:1]};
        hit    = boc_is_frame(w);
        hc     = boc_field(w);
        consec = hit && st_q.cand_vld && (hc == st_q.cand)
                 && (st_q.gap == GAP_W'(PAT_LEN - 1));
        accept = 1'b0;
        keep   = st_q.valid && hit && (hc == st_q.code);
        if (!enable) begin
            st_d.win      = '0;
            st_d.gap      = GAP_W'(PAT_LEN);
            st_d.cand_vld = 1'b0;
            st_d.rep      = '0;
            st_d.loss     = '0;
            st_d.valid    = 1'b0;
        end else if (adv) begin
            st_d.win = w;
            if (hit) begin
                st_d.gap = '0;
            end else if (st_q.gap != GAP_W'(PAT_LEN)) begin
                st_d.gap = st_q.gap + 1'b1;
            end
            if (hit) begin
                if (consec) begin
                    if (st_q.rep != REP_W'(ACCEPT_CNT)) begin
                        st_d.rep = st_q.rep + 1'b1;
                    end
                end else begin
                    st_d.cand     = hc;
                    st_d.cand_vld = 1'b1;
                    st_d.rep      = REP_W'(1);
                end
                accept = (st_d.rep == REP_W'(ACCEPT_CNT));
            end
            if (accept && !keep) begin
                st_d.valid = 1'b1;
                st_d.code  = hc;
                st_d.loss  = '0;
                chg_d      = 1'b1;
            end else if (st_q.valid) begin
                if (keep) begin
                    st_d.loss = '0;
                end else if (st_q.loss == LOSS_W'(LOSS_LIM - 1)) begin
                    st_d.valid = 1'b0;
                    st_d.loss  = '0;
                    chg_d      = 1'b1;
                end else begin
                    st_d.loss = st_q.loss + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.win      <= '0;
            st_q.gap      <= GAP_W'(PAT_LEN);
            st_q.cand     <= '0;
            st_q.cand_vld <= 1'b0;
            st_q.rep      <= '0;
            st_q.loss     <= '0;
            st_q.valid    <= 1'b0;
            st_q.code     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code   = st_q.code;
    assign valid  = st_q.valid;
    assign change = chg_d;
endmodule

// File: rtl/boc_event.sv
module boc_event (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (change) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;
endmodule

// File: rtl/boc_link_ctrl.sv
module boc_link_ctrl
    import boc_pkg::*;
#(
    parameter int ACCEPT_CNT = 3,
    parameter int LOSS_PATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t1_mode,
    input  logic              dl_strobe,
    input  logic              send_en,
    input  logic [CODE_W-1:0] tx_code,
    output logic              tx_dl_bit,
    input  logic              rx_dl_bit,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_valid,
    input  logic              event_clr,
    input  logic              irq_en,
    output logic              event_flag,
    output logic              irq
);
    logic adv;
    logic rx_change;

    assign adv = dl_strobe & t1_mode;

    boc_tx_gen u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .send_en (send_en),
        .code    (tx_code),
        .bit_out (tx_dl_bit)
    );

    boc_rx_detect #(
        .ACCEPT_CNT (ACCEPT_CNT),
        .LOSS_PATS  (LOSS_PATS)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (t1_mode),
        .adv    (adv),
        .bit_in (rx_dl_bit),
        .code   (rx_code),
        .valid  (rx_valid),
        .change (rx_change)
    );

    boc_event u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .change (rx_change),
        .clr    (event_clr),
        .irq_en (irq_en),
        .flag   (event_flag),
        .irq    (irq)
    );
endmodule

// File: rtl/boc_link_ctrl_chk.sv
module boc_link_ctrl_chk
    import boc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              t1_mode,
    input logic              dl_strobe,
    input logic              tx_dl_bit,
    input logic [CODE_W-1:0] rx_code,
    input logic              rx_valid,
    input logic              event_clr,
    input logic              event_flag
);
    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dl_strobe && t1_mode) |=> $stable(tx_dl_bit));

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dl_strobe && t1_mode) |=> ($stable(rx_valid) && $stable(rx_code)));

    assert_mode_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !t1_mode |=> !rx_valid);

    assert_valid_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> event_flag);

    assert_code_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_code) |-> (rx_valid && event_flag));

    assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(event_flag) |-> $past(event_clr));
endmodule

bind boc_link_ctrl boc_link_ctrl_chk chk_i (.*);

// File: tb/boc_link_ctrl_tb_top.sv
module boc_link_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t1_mode = 1'b1;
    logic       dl_strobe = 1'b0;
    logic       send_en = 1'b0;
    logic [5:0] tx_code = 6'h00;
    logic       tx_dl_bit;
    logic       rx_dl_bit = 1'b0;
    logic [5:0] rx_code;
    logic       rx_valid;
    logic       event_clr = 1'b0;
    logic       irq_en = 1'b1;
    logic       event_flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boc_link_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .t1_mode    (t1_mode),
        .dl_strobe  (dl_strobe),
        .send_en    (send_en),
        .tx_code    (tx_code),
        .tx_dl_bit  (tx_dl_bit),
        .rx_dl_bit  (rx_dl_bit),
        .rx_code    (rx_code),
        .rx_valid   (rx_valid),
        .event_clr  (event_clr),
        .irq_en     (irq_en),
        .event_flag (event_flag),
        .irq        (irq)
    );

    typedef struct packed {
        logic       idle;
        logic [5:0] code;
        logic [2:0] reps;
        logic       ev;
        logic [5:0] ecode;
        logic       eevt;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b0, 6'h04, 3'd2, 1'b0, 6'h00, 1'b0},
        '{1'b0, 6'h04, 3'd1, 1'b1, 6'h04, 1'b1},
        '{1'b0, 6'h0C, 3'd2, 1'b1, 6'h04, 1'b0},
        '{1'b0, 6'h0C, 3'd1, 1'b1, 6'h0C, 1'b1},
        '{1'b1, 6'h00, 3'd3, 1'b1, 6'h0C, 1'b0},
        '{1'b1, 6'h00, 3'd1, 1'b0, 6'h0C, 1'b1}
    };

    function automatic logic [15:0] frame_of(input logic [5:0] c);
        return {1'b0, c, 1'b0, 8'hFF};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic b, output logic txb);
        @(negedge clk);
        txb       = tx_dl_bit;
        rx_dl_bit = b;
        dl_strobe = 1'b1;
        @(negedge clk);
        dl_strobe = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        logic t;
        for (int i = 0; i < 16; i++) strobe(w[i], t);
    endtask

    task automatic clear_event();
        @(negedge clk);
        event_clr = 1'b1;
        @(negedge clk);
        event_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic        b;
        logic        held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R8)
        check("R1 reset tx bit", tx_dl_bit, 0);
        check("R4 reset valid", rx_valid, 0);
        check("R8 reset event", event_flag, 0);
        check("R8 reset irq", irq, 0);

        // Transmit: idle window with send raised mid-pattern (R1, R3)
        tx_code = 6'h2D;
        for (int i = 0; i < 16; i++) begin
            if (i == 8) send_en = 1'b1;
            strobe(1'b0, b);
            got[i] = b;
        end
        check("R1/R3 idle pattern", got, 16'h7E7E);
        for (int i = 0; i < 16; i++) begin
            strobe(1'b0, b);
            got[i] = b;
        end
        check("R2 code pattern", got, frame_of(6'h2D));
        for (int i = 0; i < 16; i++) begin
            if (i == 4) send_en = 1'b0;
            strobe(1'b0, b);
            got[i] = b;
        end
        check("R3 pattern completes after clear", got, frame_of(6'h2D));
        for (int i = 0; i < 16; i++) begin
            strobe(1'b0, b);
            got[i] = b;
        end
        check("R3 idle after clear", got, 16'h7E7E);

        // Receive vector table (R4, R6, R7, R8)
        for (int v = 0; v < 6; v++) begin
            for (int r = 0; r < int'(TBL[v].reps); r++)
                send_word(TBL[v].idle ? 16'h7E7E : frame_of(TBL[v].code));
            check($sformatf("R4/R6/R7 valid vec%0d", v), rx_valid, TBL[v].ev);
            if (TBL[v].ev)
                check($sformatf("R4/R6 code vec%0d", v), rx_code, TBL[v].ecode);
            check($sformatf("R8 event vec%0d", v), event_flag, TBL[v].eevt);
            clear_event();
            check($sformatf("R8 cleared vec%0d", v), event_flag, 0);
        end

        // Broken repetition restarts the count (R5)
        send_word(frame_of(6'h22));
        send_word(frame_of(6'h22));
        send_word(16'h7E7E);
        send_word(frame_of(6'h22));
        send_word(frame_of(6'h22));
        check("R5 gap restarts count", rx_valid, 0);
        check("R5 no event on restart", event_flag, 0);
        send_word(frame_of(6'h22));
        check("R5 accepted after restart", rx_valid, 1);
        check("R5 code after restart", rx_code, 6'h22);

        // Interrupt mask (R8)
        check("R8 irq enabled", irq, 1);
        @(negedge clk);
        irq_en = 1'b0;
        @(negedge clk);
        check("R8 irq masked", irq, 0);
        check("R8 flag kept under mask", event_flag, 1);
        clear_event();
        irq_en = 1'b1;
        @(negedge clk);
        check("R8 irq after clear", irq, 0);

        // No strobe: long idle in clocks does not time out (R9)
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            rx_dl_bit = i[0];
        end
        check("R9 valid held without strobes", rx_valid, 1);
        check("R9 code held without strobes", rx_code, 6'h22);
        check("R9 no event without strobes", event_flag, 0);

        // Mode off (R10)
        @(negedge clk);
        t1_mode = 1'b0;
        @(negedge clk);
        check("R10 valid cleared", rx_valid, 0);
        check("R10 no event", event_flag, 0);
        held = tx_dl_bit;
        for (int i = 0; i < 7; i++) begin
            strobe(1'b1, b);
            check("R10 tx bit frozen", tx_dl_bit, held);
        end
        send_word(frame_of(6'h11));
        send_word(frame_of(6'h11));
        send_word(frame_of(6'h11));
        check("R10 no acceptance when off", rx_valid, 0);
        @(negedge clk);
        t1_mode = 1'b1;
        send_word(frame_of(6'h15));
        send_word(frame_of(6'h15));
        send_word(frame_of(6'h15));
        check("R10/R4 reacquire valid", rx_valid, 1);
        check("R10/R4 reacquire code", rx_code, 6'h15);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule